// File: doc/BRIEF.md
# Network Controller Control/Status Register

This block holds the 16-bit control and status word of a descriptor-driven Ethernet controller, together with its interrupt request logic and a companion interrupt vector register. A host reaches both registers over a simple word-wide bus with a one-bit register select. Writes update the control fields and, by write-one-to-clear, retire pending interrupt requests. The controller's datapath sends single-cycle event pulses: transmit done, receive done, nonexistent memory, and descriptor list exhausted or reloaded. It also sends level inputs for carrier and fuse status.

The block drives a single interrupt line and presents the vector on interrupt acknowledge. It also decodes the control fields into enables for the datapath. A soft reset bit clears all pending requests and forces both descriptor lists invalid. The lists then stay invalid after the bit is released, until the datapath reports that a new list has been handed over. The internal loopback control is active low, so the word a host must write for normal operation has that bit set.

Top module: `nic_csr`

## Requirements
- R1: After the synchronous reset the status word (select 0) reads 0x0030 with carrier and fuse inputs low: both list-invalid flags set and every other bit clear. The vector register reads 0.
- R2: A write to select 0 loads the writable fields from the data: bit 0 receive enable, bit 1 soft reset, bit 3 diagnostic, bit 6 interrupt enable, bit 8 internal loopback (active low), bit 9 external loopback, bit 10 sanity timer enable. Each field reads back as written.
- R3: Bits 11 and 14 always read 0. Bits 12 and 13 read the fuse and carrier inputs. Writes have no effect on bits 2, 4, 5, 12 and 13.
- R4: A transmit-done pulse sets the transmit request (bit 7). A nonexistent-memory pulse sets both bit 2 and bit 7.
- R5: A receive-done pulse sets the receive request (bit 15) only when loopback is off, meaning bit 8 is 1 and bit 9 is 0. Otherwise the pulse has no effect.
- R6: A write to select 0 with bit 7 at 1 clears bits 7 and 2, and with bit 15 at 1 clears bit 15. A 0 in those positions leaves them unchanged. An event arriving in the same cycle as the clear wins, and the flag stays set.
- R7: The interrupt output is high exactly when bit 6 is set and bit 7 or bit 15 is set.
- R8: While bit 1 is set, bits 2, 7 and 15 are held clear and bits 4 and 5 are forced to 1. After bit 1 is written back to 0, bits 4 and 5 stay set.
- R9: When soft reset is off, a transmit list-end pulse sets bit 4 and a receive list-end pulse sets bit 5. A transmit or receive list-load pulse clears the matching bit. End wins over load in the same cycle.
- R10: Select 1 reads and writes the vector register. Only bits 2 through 8 are stored, and all other bits read 0. The acknowledge output carries the vector while acknowledge is high and 0 otherwise.
- R11: The datapath enables follow the control fields: receive enable = bit 0, soft reset = bit 1, diagnostic = bit 3, external loop = bit 9, sanity = bit 10. Internal loop is active only when bit 0 is 1 and bit 8 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 status/control, 1 vector |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register |
| xmit_done | input | 1 | Transmit completion pulse |
| rcv_done | input | 1 | Receive completion pulse |
| nxm_err | input | 1 | Nonexistent-memory (bus timeout) pulse |
| xlist_end | input | 1 | Transmit descriptor list exhausted |
| rlist_end | input | 1 | Receive descriptor list exhausted |
| xlist_load | input | 1 | New transmit list handed to the datapath |
| rlist_load | input | 1 | New receive list handed to the datapath |
| carrier | input | 1 | Carrier present level |
| fuse_ok | input | 1 | Cable fuse good level |
| iack | input | 1 | Interrupt acknowledge |
| irq | output | 1 | Interrupt request |
| iack_vector | output | 16 | Vector during acknowledge, else 0 |
| rx_enable | output | 1 | Receiver enable |
| soft_reset | output | 1 | Soft reset to the datapath |
| int_loop | output | 1 | Internal loopback active |
| ext_loop | output | 1 | External loopback active |
| sanity_en | output | 1 | Sanity timer enable |
| diag_rom | output | 1 | Diagnostic ROM select |

## Verification
The in-line assertions check several rules on every cycle. A nonexistent-memory flag never stands without the transmit request. Soft reset empties the requests and invalidates both lists one cycle later. A write-one-to-clear with no competing event drops the transmit request. A receive completion under loopback leaves the receive request clear. Control and vector writes land unchanged on the next cycle. Other behaviours can only be shown by the bench's scenarios against its model. These include event-versus-clear priority, lists that stay invalid after soft reset is released, the active-low loopback decode, read-only and reserved bit positions, and the interrupt line tracking enable across random mixes of events and writes.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

    localparam int CSR_W   = 16;
    localparam int N_LISTS = 2;
    localparam int LIST_X  = 0;
    localparam int LIST_R  = 1;

    // bit positions of the status/control word (software decodes them)
    localparam int B_RXEN   = 0;
    localparam int B_RST    = 1;
    localparam int B_NXM    = 2;
    localparam int B_DIAG   = 3;
    localparam int B_XINV   = 4;
    localparam int B_RINV   = 5;
    localparam int B_IE     = 6;
    localparam int B_XI     = 7;
    localparam int B_ILOOPN = 8;
    localparam int B_ELOOP  = 9;
    localparam int B_SANITY = 10;
    localparam int B_FUSE   = 12;
    localparam int B_CARR   = 13;
    localparam int B_RI     = 15;

    typedef struct packed {
        logic sanity;
        logic ext_loop;
        logic int_loop_n;
        logic ie;
        logic diag;
        logic soft_rst;
        logic rx_en;
    } ctrl_t;

    typedef struct packed {
        logic xi;
        logic ri;
        logic nxm;
    } req_t;

    localparam ctrl_t CTRL_RST = '{default: 1'b0};

    function automatic logic loop_selected(ctrl_t c);
        return !c.int_loop_n || c.ext_loop;
    endfunction

    function automatic logic [CSR_W-1:0] csr_word(ctrl_t c, req_t r,
                                                  logic [N_LISTS-1:0] inv,
                                                  logic fuse, logic carr);
        logic [CSR_W-1:0] w;
        w           = '0;
        w[B_RXEN]   = c.rx_en;
        w[B_RST]    = c.soft_rst;
        w[B_NXM]    = r.nxm;
        w[B_DIAG]   = c.diag;
        w[B_XINV]   = inv[LIST_X];
        w[B_RINV]   = inv[LIST_R];
        w[B_IE]     = c.ie;
        w[B_XI]     = r.xi;
        w[B_ILOOPN] = c.int_loop_n;
        w[B_ELOOP]  = c.ext_loop;
        w[B_SANITY] = c.sanity;
        w[B_FUSE]   = fuse;
        w[B_CARR]   = carr;
        w[B_RI]     = r.ri;
        return w;
    endfunction

endpackage

// File: rtl/nic_csr_ctrl.sv
module nic_csr_ctrl
    import nic_csr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_csr,
    input  ctrl_t wctrl,
    output ctrl_t ctrl
);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl <= CTRL_RST;
        else if (wr_csr)
            ctrl <= wctrl;
    end

    // R2
    ctrl_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_csr |=> (ctrl == $past(wctrl)));

endmodule

// File: rtl/nic_csr_irq.sv
module nic_csr_irq
    import nic_csr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  ctrl_t              ctrl,
    input  logic               clr_x,
    input  logic               clr_r,
    input  logic               xmit_done,
    input  logic               rcv_done,
    input  logic               nxm_err,
    input  logic [N_LISTS-1:0] list_end,
    input  logic [N_LISTS-1:0] list_load,
    output req_t               req,
    output logic [N_LISTS-1:0] list_inv,
    output logic               irq
);

    logic set_x;
    logic set_r;

    assign set_x = xmit_done || nxm_err;
    assign set_r = rcv_done && !loop_selected(ctrl);

    always_ff @(posedge clk) begin
        if (rst || ctrl.soft_rst) begin
            req <= '0;
        end else begin
            req.xi  <= set_x   ? 1'b1 : (clr_x ? 1'b0 : req.xi);
            req.nxm <= nxm_err ? 1'b1 : (clr_x ? 1'b0 : req.nxm);
            req.ri  <= set_r   ? 1'b1 : (clr_r ? 1'b0 : req.ri);
        end
    end

    for (genvar g = 0; g < N_LISTS; g++) begin : g_list
        logic inv_q;
        always_ff @(posedge clk) begin
            if (rst || ctrl.soft_rst)
                inv_q <= 1'b1;
            else if (list_end[g])
                inv_q <= 1'b1;
            else if (list_load[g])
                inv_q <= 1'b0;
        end
        assign list_inv[g] = inv_q;
    end

    assign irq = ctrl.ie && (req.xi || req.ri);

    // R4
    nxm_with_xi_chk: assert property (@(posedge clk) disable iff (rst)
        req.nxm |-> req.xi);

    // R8
    soft_reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.soft_rst |=> (!req.xi && !req.ri && !req.nxm && (&list_inv)));

    // R6
    xi_w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_x && !xmit_done && !nxm_err && !ctrl.soft_rst) |=> !req.xi);

    // R5
    rx_loop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rcv_done && loop_selected(ctrl) && !req.ri) |=> !req.ri);

endmodule

// File: rtl/nic_csr_vec.sv
module nic_csr_vec
    import nic_csr_pkg::*;
#(
    parameter int VEC_W     = 9,
    parameter int VEC_ALIGN = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_vec,
    input  logic [CSR_W-1:0] wdata,
    input  logic             iack,
    output logic [CSR_W-1:0] vec_rd,
    output logic [CSR_W-1:0] iack_vector
);

    localparam logic [CSR_W-1:0] ONES  = {CSR_W{1'b1}};
    localparam logic [CSR_W-1:0] VMASK = (ONES >> (CSR_W - VEC_W)) & (ONES << VEC_ALIGN);

    logic [CSR_W-1:0] vec_q;

    always_ff @(posedge clk) begin
        if (rst)
            vec_q <= '0;
        else if (wr_vec)
            vec_q <= wdata & VMASK;
    end

    assign vec_rd      = vec_q;
    assign iack_vector = iack ? vec_q : '0;

    // R10
    vec_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_vec |=> (vec_rd == ($past(wdata) & VMASK)));

endmodule

// File: rtl/nic_csr.sv
module nic_csr
    import nic_csr_pkg::*;
#(
    parameter int VEC_W     = 9,
    parameter int VEC_ALIGN = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        xmit_done,
    input  logic        rcv_done,
    input  logic        nxm_err,
    input  logic        xlist_end,
    input  logic        rlist_end,
    input  logic        xlist_load,
    input  logic        rlist_load,
    input  logic        carrier,
    input  logic        fuse_ok,
    input  logic        iack,
    output logic        irq,
    output logic [15:0] iack_vector,
    output logic        rx_enable,
    output logic        soft_reset,
    output logic        int_loop,
    output logic        ext_loop,
    output logic        sanity_en,
    output logic        diag_rom
);

    logic               wr_csr;
    logic               wr_vec;
    ctrl_t              wctrl;
    ctrl_t              ctrl;
    req_t               req;
    logic [N_LISTS-1:0] list_inv;
    logic [N_LISTS-1:0] list_end;
    logic [N_LISTS-1:0] list_load;
    logic [CSR_W-1:0]   vec_rd;
    logic [CSR_W-1:0]   csr_rd;

    assign wr_csr = bus_wr && !bus_addr;
    assign wr_vec = bus_wr &&  bus_addr;

    always_comb begin
        wctrl.rx_en      = bus_wdata[B_RXEN];
        wctrl.soft_rst   = bus_wdata[B_RST];
        wctrl.diag       = bus_wdata[B_DIAG];
        wctrl.ie         = bus_wdata[B_IE];
        wctrl.int_loop_n = bus_wdata[B_ILOOPN];
        wctrl.ext_loop   = bus_wdata[B_ELOOP];
        wctrl.sanity     = bus_wdata[B_SANITY];
    end

    always_comb begin
        list_end          = '0;
        list_load         = '0;
        list_end[LIST_X]  = xlist_end;
        list_end[LIST_R]  = rlist_end;
        list_load[LIST_X] = xlist_load;
        list_load[LIST_R] = rlist_load;
    end

    nic_csr_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_csr (wr_csr),
        .wctrl  (wctrl),
        .ctrl   (ctrl)
    );

    nic_csr_irq u_irq (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .clr_x     (wr_csr && bus_wdata[B_XI]),
        .clr_r     (wr_csr && bus_wdata[B_RI]),
        .xmit_done (xmit_done),
        .rcv_done  (rcv_done),
        .nxm_err   (nxm_err),
        .list_end  (list_end),
        .list_load (list_load),
        .req       (req),
        .list_inv  (list_inv),
        .irq       (irq)
    );

    nic_csr_vec #(
        .VEC_W     (VEC_W),
        .VEC_ALIGN (VEC_ALIGN)
    ) u_vec (
        .clk         (clk),
        .rst         (rst),
        .wr_vec      (wr_vec),
        .wdata       (bus_wdata),
        .iack        (iack),
        .vec_rd      (vec_rd),
        .iack_vector (iack_vector)
    );

    always_comb begin
        csr_rd    = csr_word(ctrl, req, list_inv, fuse_ok, carrier);
        bus_rdata = bus_addr ? vec_rd : csr_rd;
    end

    assign rx_enable  = ctrl.rx_en;
    assign soft_reset = ctrl.soft_rst;
    assign int_loop   = ctrl.rx_en && !ctrl.int_loop_n;
    assign ext_loop   = ctrl.ext_loop;
    assign sanity_en  = ctrl.sanity;
    assign diag_rom   = ctrl.diag;

    // R7
    irq_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (req.xi || req.ri));

endmodule

// File: tb/nic_csr_test.sv
module nic_csr_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] WMASK = 16'h074B;
    localparam logic [15:0] VMASK = 16'h01FC;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0, bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata, iack_vector;
    logic xmit_done = 0, rcv_done = 0, nxm_err = 0;
    logic xlist_end = 0, rlist_end = 0, xlist_load = 0, rlist_load = 0;
    logic carrier = 0, fuse_ok = 0, iack = 0;
    logic irq, rx_enable, soft_reset, int_loop, ext_loop, sanity_en, diag_rom;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_ctrl, m_vec;
    logic m_xi, m_ri, m_nxm, m_xinv, m_rinv;

    always #(CLK_PERIOD/2) clk = ~clk;

    nic_csr uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .xmit_done(xmit_done), .rcv_done(rcv_done), .nxm_err(nxm_err),
        .xlist_end(xlist_end), .rlist_end(rlist_end),
        .xlist_load(xlist_load), .rlist_load(rlist_load),
        .carrier(carrier), .fuse_ok(fuse_ok), .iack(iack),
        .irq(irq), .iack_vector(iack_vector),
        .rx_enable(rx_enable), .soft_reset(soft_reset), .int_loop(int_loop),
        .ext_loop(ext_loop), .sanity_en(sanity_en), .diag_rom(diag_rom)
    );

    task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_csr();
        logic [15:0] w;
        w = m_ctrl;
        w[2] = m_nxm; w[4] = m_xinv; w[5] = m_rinv; w[7] = m_xi;
        w[12] = fuse_ok; w[13] = carrier; w[15] = m_ri;
        return w;
    endfunction

    function automatic logic [15:0] exp_outs();
        return {10'd0, m_ctrl[3], m_ctrl[10], m_ctrl[9],
                m_ctrl[0] & ~m_ctrl[8], m_ctrl[1], m_ctrl[0]};
    endfunction

    task automatic check_all(string tag);
        chk(tag, "rdata", bus_rdata, bus_addr ? m_vec : exp_csr());
        // R7
        chk("R7", "irq", {15'd0, irq}, {15'd0, m_ctrl[6] & (m_xi | m_ri)});
        // R10
        chk("R10", "iack_vector", iack_vector, iack ? m_vec : 16'h0);
        // R11
        chk("R11", "enables",
            {10'd0, diag_rom, sanity_en, ext_loop, int_loop, soft_reset, rx_enable},
            exp_outs());
    endtask

    task automatic tick(string tag);
        logic sr, lp, w1x, w1r, wc;
        logic [15:0] n_ctrl, n_vec;
        logic n_xi, n_ri, n_nxm, n_xinv, n_rinv;
        sr  = m_ctrl[1];
        lp  = !m_ctrl[8] || m_ctrl[9];
        wc  = bus_wr && !bus_addr;
        w1x = wc && bus_wdata[7];
        w1r = wc && bus_wdata[15];
        n_ctrl = wc ? (bus_wdata & WMASK) : m_ctrl;
        n_vec  = (bus_wr && bus_addr) ? (bus_wdata & VMASK) : m_vec;
        if (sr) begin
            n_xi = 0; n_ri = 0; n_nxm = 0; n_xinv = 1; n_rinv = 1;
        end else begin
            n_xi   = (xmit_done || nxm_err) ? 1'b1 : (w1x ? 1'b0 : m_xi);
            n_nxm  = nxm_err ? 1'b1 : (w1x ? 1'b0 : m_nxm);
            n_ri   = (rcv_done && !lp) ? 1'b1 : (w1r ? 1'b0 : m_ri);
            n_xinv = xlist_end ? 1'b1 : (xlist_load ? 1'b0 : m_xinv);
            n_rinv = rlist_end ? 1'b1 : (rlist_load ? 1'b0 : m_rinv);
        end
        @(posedge clk);
        @(negedge clk);
        m_ctrl = n_ctrl; m_vec = n_vec; m_xi = n_xi; m_ri = n_ri;
        m_nxm = n_nxm; m_xinv = n_xinv; m_rinv = n_rinv;
        check_all(tag);
        bus_wr = 0; xmit_done = 0; rcv_done = 0; nxm_err = 0;
        xlist_end = 0; rlist_end = 0; xlist_load = 0; rlist_load = 0;
    endtask

    task automatic wr_csr(logic [15:0] d, string tag);
        bus_wr = 1; bus_addr = 0; bus_wdata = d;
        tick(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1
        chk("R1", "reset csr", bus_rdata, 16'h0030);
        chk("R1", "reset irq", {15'd0, irq}, 16'h0);
        bus_addr = 1; #1;
        chk("R1", "reset vector", bus_rdata, 16'h0000);
        bus_addr = 0;
        m_ctrl = 0; m_vec = 0; m_xi = 0; m_ri = 0; m_nxm = 0; m_xinv = 1; m_rinv = 1;
        @(negedge clk);

        // R2 and R8: all ones enters soft reset
        wr_csr(16'hFFFF, "R2");
        tick("R8");
        // R2 normal mode: rx enable, IE, bit 8 high
        wr_csr(16'h0141, "R2");
        // R8 lists remain invalid after release
        tick("R8");
        // R9 list loads, end wins over load
        xlist_load = 1; tick("R9");
        rlist_load = 1; tick("R9");
        xlist_end = 1; xlist_load = 1; tick("R9");
        xlist_load = 1; tick("R9");
        // R3 read-only and reserved bits
        fuse_ok = 1; carrier = 1;
        wr_csr(16'h7875 | 16'h0141, "R3");
        wr_csr(16'h0141, "R3");
        // R4 events
        xmit_done = 1; tick("R4");
        wr_csr(16'h0141 | 16'h0080, "R6");
        nxm_err = 1; tick("R4");
        // R5 receive in normal mode
        rcv_done = 1; tick("R5");
        // R6 write zero leaves flags
        wr_csr(16'h0141, "R6");
        // R6 collision: event and clear in one cycle
        rcv_done = 1; bus_wr = 1; bus_wdata = 16'h8141; tick("R6");
        wr_csr(16'h8141 | 16'h0080, "R6");
        // R5 loopback blocks receive request; R11 internal loop decode
        wr_csr(16'h0041, "R11");
        rcv_done = 1; tick("R5");
        wr_csr(16'h0341, "R11");
        rcv_done = 1; tick("R5");
        // R7 irq gated by enable
        wr_csr(16'h0101, "R7");
        xmit_done = 1; tick("R7");
        wr_csr(16'h0141, "R7");
        // R8 soft reset with pending request
        wr_csr(16'h0143, "R8");
        tick("R8");
        xmit_done = 1; rcv_done = 1; tick("R8");
        wr_csr(16'h0141, "R8");
        // R10 vector
        bus_wr = 1; bus_addr = 1; bus_wdata = 16'hFFFF; tick("R10");
        iack = 1; tick("R10");
        iack = 0; bus_wr = 1; bus_addr = 1; bus_wdata = 16'h00A7; tick("R10");
        iack = 1; tick("R10");
        iack = 0; bus_addr = 0; tick("R10");

        // random phase
        void'($urandom(32'd20250611));
        for (int i = 0; i < 3000; i++) begin
            bus_wr     = ($urandom % 4) == 0;
            bus_addr   = ($urandom % 3) == 0;
            bus_wdata  = 16'($urandom);
            if (bus_wdata[1] && ($urandom % 8) != 0) bus_wdata[1] = 1'b0;
            xmit_done  = ($urandom % 6) == 0;
            rcv_done   = ($urandom % 6) == 0;
            nxm_err    = ($urandom % 12) == 0;
            xlist_end  = ($urandom % 10) == 0;
            rlist_end  = ($urandom % 10) == 0;
            xlist_load = ($urandom % 5) == 0;
            rlist_load = ($urandom % 5) == 0;
            carrier    = ($urandom % 2) == 0;
            fuse_ok    = ($urandom % 2) == 0;
            iack       = ($urandom % 4) == 0;
            tick("R4/R5/R6/R8/R9/R3");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule